// File: doc/BRIEF.md
# Decoded System Memory Map

This block is the memory side of a processor bus with a 20-bit byte address and an 8-bit data path. It looks at the top of the address to decide which device the bus cycle is meant for. One 64K window holds a read/write RAM. A second 64K window holds a read-only image that is split into eight 8K blocks. Every other address is unmapped. The bus uses two active-low strobes, one for read and one for write. The block turns each strobe into per-device enables, so that a device is enabled only when it is selected and a single strobe is active.

Reads return their byte one clock after the read strobe is sampled, together with a one-cycle valid flag. The RAM keeps its storage in a synchronous array whose depth is a parameter. The read-only image is not stored. It is computed from the block number, the offset and a seed parameter, so no file or memory content is needed. Any write that the block cannot perform raises a one-cycle error pulse. This covers a write to the read-only window, a write to an unmapped address, and a cycle with both strobes asserted.

Data moves on plain strobes. There is no valid/ready pair, and the block never applies back-pressure: every strobe is accepted in the cycle it is sampled. The chip selects and enables are brought out as ports so the decode can be observed.

Top module: `decoded_memmap`

## Requirements
- R1: `ram_cs_n` is low in the same cycle exactly when `addr[19:16]` equals 4'hE.
- R2: When `addr[19:16]` equals 4'hF, exactly one bit of `rom_cs_n` is low. That bit is the one indexed by `addr[15:13]`, and `ram_cs_n` stays high.
- R3: For any other value of `addr[19:16]`, no chip select is low. A read there gives `rd_valid`=1 and `rd_data`=8'hFF in the next cycle.
- R4: A RAM write (`wr_n`=0, `rd_n`=1) stores `wr_data` at index `addr[RAM_AW-1:0]`, where RAM_AW defaults to 12. The upper offset bits alias onto the same cell. A later RAM read returns the stored byte on `rd_data`, with `rd_valid`=1, one cycle after the read strobe is sampled.
- R5: A read in the read-only window returns `addr[7:0] ^ addr[15:8] ^ 8'h5A` one cycle later, with `rd_valid`=1.
- R6: `ram_we_n` is low only for a RAM-window address with only `wr_n` low. `ram_oe_n` is low only for a RAM-window address with only `rd_n` low. The two are never low together.
- R7: `rom_oe_n` is low only for a read-only-window address with only `rd_n` low.
- R8: If `rd_n` and `wr_n` are both low, `bus_err` is 1 in the next cycle. `rd_valid` stays 0, and nothing is written.
- R9: A write to the read-only window or to an unmapped address changes no RAM cell. It gives `bus_err`=1 for exactly the next cycle.
- R10: With both strobes high, the next cycle shows `rd_valid`=0, `rd_data`=8'hFF and `bus_err`=0.
- R11: At most one chip select (`ram_cs_n` or any `rom_cs_n` bit) is low in any cycle.
- R12: During and right after reset, `rd_valid`=0, `rd_data`=8'hFF and `bus_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | Byte address |
| wr_data | input | 8 | Write data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_data | output | 8 | Read data, 8'hFF when no read answered |
| rd_valid | output | 1 | Read data valid, one cycle per read |
| bus_err | output | 1 | One-cycle error pulse |
| ram_cs_n | output | 1 | RAM window select, active low |
| rom_cs_n | output | 8 | Read-only block selects, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| rom_oe_n | output | 1 | Read-only output enable, active low |

## Verification
Random addresses are drawn from the RAM window, the read-only window and the unmapped space. The RAM offsets reuse a small pool of cells while the aliased upper offset bits vary at random, so a wrong index width shows up as a wrong read-back. Strobe pairs are drawn so that read, write, idle and conflict cycles each appear often. Each kind of cycle separates different faults. Conflict cycles separate a missed error from a write that leaked through. Writes outside the RAM window separate error decode from storage corruption. Reads in each of the eight blocks separate the block select from the pattern bits.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_ROM  = 2'd2,
    SRC_FILL = 2'd3
  } src_e;
endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode #(
  parameter int TAG_W = 4,
  parameter int BLK_W = 3,
  parameter logic [TAG_W-1:0] RAM_TAG = 4'hE,
  parameter logic [TAG_W-1:0] ROM_TAG = 4'hF,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [BLK_W-1:0] blk,
  output logic             ram_sel,
  output logic             rom_sel,
  output logic [NBLK-1:0]  blk_cs_n
);
  assign ram_sel = (tag == RAM_TAG);
  assign rom_sel = (tag == ROM_TAG);

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign blk_cs_n[i] = !(rom_sel && (blk == BLK_W'(i)));
  end
endmodule

// File: rtl/mm_strobe_gate.sv
module mm_strobe_gate (
  input  logic rd_n,
  input  logic wr_n,
  input  logic ram_sel,
  input  logic rom_sel,
  output logic rd_go,
  output logic wr_go,
  output logic conflict,
  output logic ram_we_n,
  output logic ram_oe_n,
  output logic rom_oe_n
);
  assign conflict = !rd_n && !wr_n;
  assign rd_go    = !rd_n && wr_n;
  assign wr_go    = !wr_n && rd_n;
  assign ram_we_n = !(ram_sel && wr_go);
  assign ram_oe_n = !(ram_sel && rd_go);
  assign rom_oe_n = !(rom_sel && rd_go);
endmodule

// File: rtl/mm_ram_store.sv
module mm_ram_store #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/mm_rom_image.sv
module mm_rom_image #(
  parameter int BLK_W = 3,
  parameter int OFF_W = 13,
  parameter int DW = 8,
  parameter logic [DW-1:0] SEED = 8'h5A
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [OFF_W-1:0] off,
  output logic [DW-1:0]    data
);
  logic [BLK_W+OFF_W-1:0] full;
  assign full = {blk, off};
  assign data = DW'(full) ^ DW'(full >> DW) ^ SEED;
endmodule

// File: rtl/decoded_memmap.sv
module decoded_memmap #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int TAG_W = 4,
  parameter int BLK_W = 3,
  parameter int RAM_AW = 12,
  parameter logic [TAG_W-1:0] RAM_TAG = 4'hE,
  parameter logic [TAG_W-1:0] ROM_TAG = 4'hF,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'h5A,
  localparam int WIN_AW = ADDR_W - TAG_W,
  localparam int OFF_W = WIN_AW - BLK_W,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_err,
  output logic              ram_cs_n,
  output logic [NBLK-1:0]   rom_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              rom_oe_n
);
  import mm_pkg::*;

  logic ram_sel, rom_sel, rd_go, wr_go, conflict;
  logic [DATA_W-1:0] ram_q, rom_byte, rom_q;
  src_e src_d, src_q;
  logic err_d, err_q;

  mm_addr_decode #(
    .TAG_W(TAG_W), .BLK_W(BLK_W), .RAM_TAG(RAM_TAG), .ROM_TAG(ROM_TAG)
  ) u_dec (
    .tag(addr[ADDR_W-1 -: TAG_W]),
    .blk(addr[WIN_AW-1 -: BLK_W]),
    .ram_sel(ram_sel),
    .rom_sel(rom_sel),
    .blk_cs_n(rom_cs_n)
  );

  assign ram_cs_n = !ram_sel;

  mm_strobe_gate u_gate (
    .rd_n(rd_n), .wr_n(wr_n), .ram_sel(ram_sel), .rom_sel(rom_sel),
    .rd_go(rd_go), .wr_go(wr_go), .conflict(conflict),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .rom_oe_n(rom_oe_n)
  );

  mm_ram_store #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk),
    .we(!ram_we_n),
    .re(!ram_oe_n),
    .idx(addr[RAM_AW-1:0]),
    .wdata(wr_data),
    .q(ram_q)
  );

  mm_rom_image #(.BLK_W(BLK_W), .OFF_W(OFF_W), .DW(DATA_W), .SEED(ROM_SEED)) u_rom (
    .blk(addr[WIN_AW-1 -: BLK_W]),
    .off(addr[OFF_W-1:0]),
    .data(rom_byte)
  );

  always_comb begin
    src_d = SRC_NONE;
    if (rd_go) begin
      if (ram_sel)      src_d = SRC_RAM;
      else if (rom_sel) src_d = SRC_ROM;
      else              src_d = SRC_FILL;
    end
    err_d = conflict || (wr_go && !ram_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      err_q <= 1'b0;
      rom_q <= '1;
    end else begin
      src_q <= src_d;
      err_q <= err_d;
      if (src_d == SRC_ROM) rom_q <= rom_byte;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM: rd_data = ram_q;
      SRC_ROM: rd_data = rom_q;
      default: rd_data = '1;
    endcase
  end

  assign rd_valid = (src_q != SRC_NONE);
  assign bus_err  = err_q;
endmodule

// File: rtl/decoded_memmap_chk.sv
module decoded_memmap_chk #(
  parameter int NBLK = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              bus_err,
  input logic              ram_cs_n,
  input logic [NBLK-1:0]   rom_cs_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              rom_oe_n
);
  a_r11_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~{ram_cs_n, rom_cs_n}) <= 1);

  a_r6_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  a_r7_rom_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!rd_n && wr_n && !(&rom_cs_n)));

  a_r8_conflict_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> (bus_err && !rd_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |=> (!rd_valid && !bus_err && (&rd_data)));

  a_r3_unmapped_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && wr_n && ram_cs_n && (&rom_cs_n)) |=> (rd_valid && (&rd_data)));

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && ram_cs_n) |=> bus_err);
endmodule

bind decoded_memmap decoded_memmap_chk #(.NBLK(NBLK), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
  .rd_data(rd_data), .rd_valid(rd_valid), .bus_err(bus_err),
  .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
  .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .rom_oe_n(rom_oe_n)
);

// File: tb/tb_decoded_memmap.sv
module tb_decoded_memmap;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] rd_data;
  logic rd_valid, bus_err, ram_cs_n, ram_we_n, ram_oe_n, rom_oe_n;
  logic [7:0] rom_cs_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] shadow [4096];

  always #(PERIOD/2) clk = ~clk;

  decoded_memmap dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_n(rd_n), .wr_n(wr_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .bus_err(bus_err), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .rom_oe_n(rom_oe_n)
  );

  function automatic logic [7:0] rom_model(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [11:0] pool_idx(input int k);
    return 12'((k * 37 + 5) % 4096);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [19:0] a, input logic r_n, input logic w_n, input logic [7:0] d);
    logic is_ram, is_rom, rdg, wrg, conf;
    logic [7:0] exp_cs, exp_d;
    logic exp_v, exp_e;
    string rq;
    @(negedge clk);
    addr = a; rd_n = r_n; wr_n = w_n; wr_data = d;
    #1;
    is_ram = (a[19:16] == 4'hE);
    is_rom = (a[19:16] == 4'hF);
    rdg = !r_n && w_n;
    wrg = !w_n && r_n;
    conf = !r_n && !w_n;
    exp_cs = is_rom ? ~(8'd1 << a[15:13]) : 8'hFF;
    chk(ram_cs_n == !is_ram, "R1", 32'(ram_cs_n), 32'(!is_ram));
    chk(rom_cs_n == exp_cs, is_rom ? "R2" : "R3", 32'(rom_cs_n), 32'(exp_cs));
    chk({ram_we_n, ram_oe_n} == {!(is_ram && wrg), !(is_ram && rdg)}, "R6",
        32'({ram_we_n, ram_oe_n}), 32'({!(is_ram && wrg), !(is_ram && rdg)}));
    chk(rom_oe_n == !(is_rom && rdg), "R7", 32'(rom_oe_n), 32'(!(is_rom && rdg)));
    exp_v = rdg;
    exp_d = !rdg ? 8'hFF : is_ram ? shadow[a[11:0]] : is_rom ? rom_model(a) : 8'hFF;
    exp_e = conf || (wrg && !is_ram);
    if (conf) rq = "R8";
    else if (wrg && !is_ram) rq = "R9";
    else if (wrg) rq = "R4";
    else if (!rdg) rq = "R10";
    else if (is_ram) rq = "R4";
    else if (is_rom) rq = "R5";
    else rq = "R3";
    @(posedge clk);
    if (wrg && is_ram) shadow[a[11:0]] = d;
    #1;
    chk({rd_valid, rd_data, bus_err} == {exp_v, exp_d, exp_e}, rq,
        32'({rd_valid, rd_data, bus_err}), 32'({exp_v, exp_d, exp_e}));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk({rd_valid, rd_data, bus_err} == {1'b0, 8'hFF, 1'b0}, "R12",
        32'({rd_valid, rd_data, bus_err}), 32'({1'b0, 8'hFF, 1'b0}));
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk({rd_valid, rd_data, bus_err} == {1'b0, 8'hFF, 1'b0}, "R12",
        32'({rd_valid, rd_data, bus_err}), 32'({1'b0, 8'hFF, 1'b0}));

    // R4: fill the pool cells, read back through aliased offsets
    for (int k = 0; k < 16; k++) op({4'hE, 4'h0, pool_idx(k)}, 1'b1, 1'b0, 8'(k * 29 + 3));
    for (int k = 0; k < 16; k++) op({4'hE, 4'(k), pool_idx(k)}, 1'b0, 1'b1, 8'h00);
    // R5/R2: one read in each block, both ends of the offset
    for (int b = 0; b < 8; b++) op({4'hF, 3'(b), 13'h0000}, 1'b0, 1'b1, 8'h00);
    for (int b = 0; b < 8; b++) op({4'hF, 3'(b), 13'h1FFF}, 1'b0, 1'b1, 8'h00);
    // R8: conflict on a RAM cell, then prove it held
    op({4'hE, 4'h3, pool_idx(2)}, 1'b0, 1'b0, 8'hC3);
    op({4'hE, 4'h0, pool_idx(2)}, 1'b0, 1'b1, 8'h00);
    // R9: writes outside RAM window, aliases of pool cell 4, then read it
    op({4'hF, 4'h0, pool_idx(4)}, 1'b1, 1'b0, 8'h99);
    op({4'h2, 4'h0, pool_idx(4)}, 1'b1, 1'b0, 8'h66);
    op({4'hE, 4'h0, pool_idx(4)}, 1'b0, 1'b1, 8'h00);
    // R3 / R10 corners
    op(20'hDFFFF, 1'b0, 1'b1, 8'h00);
    op(20'h00000, 1'b0, 1'b1, 8'h00);
    op(20'hEFFFF, 1'b1, 1'b1, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [19:0] a;
      logic [3:0] tg;
      int sel, st;
      sel = int'($urandom % 3);
      tg = (sel == 0) ? 4'hE : (sel == 1) ? 4'hF : 4'($urandom % 14);
      a = {tg, 16'($urandom)};
      if (tg == 4'hE) a[11:0] = pool_idx(int'($urandom % 16));
      st = int'($urandom % 4);
      op(a, st[0], st[1], 8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule